// File: doc/BRIEF.md
# Glitch-filtered PS/2 keyboard receiver

This block takes the two open-collector lines of a PS/2 keyboard, sampled by a fast system clock, and turns each frame the keyboard sends into a byte. Each raw line first goes through a two-flop synchronizer and then a hold filter. The filter adopts a new level only after the synchronized input has differed from the current filtered level for a set number of system clocks. When the filter adopts a new level it emits a one-cycle change strobe. The receiver never looks at a raw edge. It acts only on cycles where the keyboard-clock strobe fires and the filtered clock is low, which is a clean falling edge.

A frame is opened only by a falling edge seen while the filtered data line is low, which is the start bit. The data bits that follow are shifted in, and the parity and stop bits are checked. A good frame lands in the output byte register and raises a valid flag that serves as the interrupt. The flag stays up until the host pulses the acknowledge input. A frame with a bad parity or stop bit raises an error flag instead. A frame that stalls for about 2 ms is dropped, so the receiver returns to idle and waits for a new start bit.

Top module: `ps2_kbd_rx`

## Requirements
- R1: After reset, `rx_byte` is 0 and `rx_valid`, `rx_err` and `rx_overrun` are all 0.
- R2: The filter hold time is HOLD = CLK_HZ/LINE_HZ system clocks. A raw pulse on either line that is shorter than HOLD clocks has no effect on the received data or on the flags.
- R3: The frame format is as follows.
  - The keyboard sends 11 bits, each taken on a falling edge of the filtered keyboard clock.
  - The first bit is a start bit of 0.
  - Next come eight data bits, least significant bit first.
  - Next comes a parity bit chosen so that the eight data bits plus the parity bit hold an odd number of ones.
  - The last bit is a stop bit of 1.
  - A good frame loads its data byte into `rx_byte` and sets `rx_valid`.
- R4: A falling edge of the keyboard clock while idle with the data line high starts no frame and has no effect.
- R5: A frame with wrong parity sets `rx_err`. It leaves `rx_valid` and `rx_byte` unchanged.
- R6: A frame whose stop bit is 0 sets `rx_err`. It leaves `rx_valid` and `rx_byte` unchanged.
- R7: `rx_valid`, `rx_err` and `rx_overrun` hold their state until `ack` is high for one cycle, and `ack` clears all three. When a good frame completes in the same cycle as `ack`, the result is `rx_valid` set and `rx_overrun` clear.
- R8: A good frame that completes while `rx_valid` is still set, with no `ack` in that cycle, sets `rx_overrun` and replaces `rx_byte` with the new byte.
- R9: A frame in progress is abandoned when no falling edge arrives for CLK_HZ/500 system clocks. The next frame is then received correctly from its start bit.
- R10: `rx_byte` changes only when a good frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_raw | input | 1 | Raw keyboard clock line |
| ps2_dat_raw | input | 1 | Raw keyboard data line |
| ack | input | 1 | One-cycle acknowledge; clears the flags |
| rx_byte | output | 8 | Last good received byte |
| rx_valid | output | 1 | New byte available (interrupt) |
| rx_err | output | 1 | Parity or stop-bit error seen |
| rx_overrun | output | 1 | A byte arrived before the previous one was acknowledged |

## Verification
The hardest cases to reach are the ones where the receiver must ignore something. One is a sub-hold glitch on the clock line while the data line is low, which a raw-edge design would take as a start bit. The other is a frame that stalls partway, which would misalign every byte after it. The stimulus holds data low and pulses the clock line for fewer clocks than the hold time. It also sends a five-bit partial frame and then waits past the timeout. In both cases the stimulus then sends a complete frame, so a wrongly accepted edge shows up as a corrupted byte at the ports. The data path is covered by a sweep over all 256 byte values at a small clock ratio.

// File: rtl/ps2_kbd_rx.sv
module ps2_kbd_rx #(
  parameter int CLK_HZ  = 25_000_000,
  parameter int LINE_HZ = 90_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_raw,
  input  logic       ps2_dat_raw,
  input  logic       ack,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       rx_err,
  output logic       rx_overrun
);
  localparam int HOLD = (CLK_HZ / LINE_HZ < 2) ? 2 : CLK_HZ / LINE_HZ;
  localparam int HW   = $clog2(HOLD + 1);
  localparam int TOUT = (CLK_HZ / 500 < 2) ? 2 : CLK_HZ / 500;
  localparam int TW   = $clog2(TOUT + 1);

  // line index 0 = keyboard clock, 1 = keyboard data
  logic [1:0]    s1, s2, lvl, stb;
  logic [HW-1:0] hcnt [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1  <= 2'b11;
      s2  <= 2'b11;
      lvl <= 2'b11;
      stb <= 2'b00;
      for (int i = 0; i < 2; i++) hcnt[i] <= '0;
    end else begin
      s1 <= {ps2_dat_raw, ps2_clk_raw};
      s2 <= s1;
      for (int i = 0; i < 2; i++) begin
        stb[i] <= 1'b0;
        if (s2[i] != lvl[i]) begin
          if (hcnt[i] == HW'(HOLD - 1)) begin
            lvl[i]  <= s2[i];
            stb[i]  <= 1'b1;
            hcnt[i] <= '0;
          end else begin
            hcnt[i] <= hcnt[i] + 1'b1;
          end
        end else begin
          hcnt[i] <= '0;
        end
      end
    end
  end

  wire fall = stb[0] & ~lvl[0];
  wire din  = lvl[1];

  logic [3:0]    bcnt;
  logic [7:0]    sh;
  logic          par;
  logic [TW-1:0] tcnt;

  wire at_stop = fall && (bcnt == 4'd10);
  wire good    = at_stop && din && par;
  wire bad     = at_stop && !(din && par);
  wire tmo     = (bcnt != 4'd0) && !fall && (tcnt == TW'(TOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= '0;
      sh   <= '0;
      par  <= 1'b0;
      tcnt <= '0;
    end else if (fall) begin
      tcnt <= '0;
      if (bcnt == 4'd0) begin
        if (!din) begin
          bcnt <= 4'd1;
          par  <= 1'b0;
        end
      end else if (bcnt <= 4'd8) begin
        sh   <= {din, sh[7:1]};
        par  <= par ^ din;
        bcnt <= bcnt + 4'd1;
      end else if (bcnt == 4'd9) begin
        par  <= par ^ din;
        bcnt <= 4'd10;
      end else begin
        bcnt <= 4'd0;
      end
    end else if (tmo) begin
      bcnt <= '0;
      tcnt <= '0;
    end else if (bcnt != 4'd0) begin
      tcnt <= tcnt + 1'b1;
    end else begin
      tcnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_byte    <= '0;
      rx_valid   <= 1'b0;
      rx_err     <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (ack) begin
        rx_valid   <= 1'b0;
        rx_err     <= 1'b0;
        rx_overrun <= 1'b0;
      end
      if (good) begin
        rx_byte  <= sh;
        rx_valid <= 1'b1;
        if (rx_valid && !ack) rx_overrun <= 1'b1;
      end
      if (bad) rx_err <= 1'b1;
    end
  end

  assert_filter_follows_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb[0] |-> (lvl[0] == $past(s2[0])));

  assert_bitcount_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= 4'd10);

  assert_valid_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ack) |=> rx_valid);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !good && !bad) |=> (!rx_valid && !rx_err && !rx_overrun));

  assert_overrun_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_valid));

  assert_byte_only_on_good_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> rx_valid);

  assert_timeout_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (bcnt == 4'd0));
endmodule

// File: tb/ps2_kbd_rx_tb.sv
module ps2_kbd_rx_tb;
  localparam int CLK_HZ  = 4_000_000;
  localparam int LINE_HZ = 1_000_000;
  localparam int HOLD    = CLK_HZ / LINE_HZ;
  localparam int TOUT    = CLK_HZ / 500;
  localparam int H       = 16;

  logic clk = 0, rst_n = 0, kclk = 1, kdat = 1, ack = 0;
  logic [7:0] rx_byte;
  logic rx_valid, rx_err, rx_overrun;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ps2_kbd_rx #(.CLK_HZ(CLK_HZ), .LINE_HZ(LINE_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .ps2_clk_raw(kclk), .ps2_dat_raw(kdat),
    .ack(ack), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_err(rx_err),
    .rx_overrun(rx_overrun));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit badpar, input bit stopv, input int nbits);
    logic [10:0] bits;
    bits = {stopv, (~^b) ^ badpar, b, 1'b0};
    for (int i = 0; i < nbits; i++) begin
      kdat = bits[i];
      wait_n(H);
      kclk = 0;
      wait_n(H);
      kclk = 1;
    end
    wait_n(H);
    kdat = 1;
    wait_n(4);
  endtask

  task automatic do_ack();
    @(negedge clk) ack = 1;
    @(negedge clk) ack = 0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    wait_n(5);
    rst_n = 1;
    wait_n(2);
    // R1
    chk(rx_byte == 0 && !rx_valid && !rx_err && !rx_overrun, "R1 reset",
        {rx_byte, rx_valid, rx_err, rx_overrun}, 0);

    // R4: falling edges with data high while idle
    for (int k = 0; k < 3; k++) begin
      wait_n(H); kclk = 0; wait_n(H); kclk = 1;
    end
    wait_n(H);
    chk(!rx_valid && !rx_err, "R4 idle edges", {rx_valid, rx_err}, 0);
    send(8'hA5, 0, 1, 11);
    chk(rx_valid && rx_byte == 8'hA5 && !rx_err, "R4 frame after idle edges", rx_byte, 8'hA5);
    do_ack();

    // R2: short clock glitches with data low
    kdat = 0;
    wait_n(H);
    for (int k = 0; k < 3; k++) begin
      kclk = 0; wait_n(HOLD - 2); kclk = 1; wait_n(H);
    end
    kdat = 1;
    wait_n(H);
    chk(!rx_valid && !rx_err, "R2 glitch ignored", {rx_valid, rx_err}, 0);
    send(8'h3C, 0, 1, 11);
    chk(rx_valid && rx_byte == 8'h3C && !rx_err, "R2 frame after glitch", rx_byte, 8'h3C);
    do_ack();

    // R3 sweep, R7 ack clears
    for (int b = 0; b < 256; b++) begin
      send(8'(b), 0, 1, 11);
      chk(rx_valid && rx_byte == 8'(b) && !rx_err && !rx_overrun, "R3 byte", rx_byte, b);
      do_ack();
      chk(!rx_valid, "R7 ack clears valid", rx_valid, 0);
    end

    // R5 parity error
    send(8'h5A, 0, 1, 11);
    do_ack();
    send(8'hC3, 1, 1, 11);
    chk(rx_err && !rx_valid, "R5 parity err flags", {rx_err, rx_valid}, 2);
    chk(rx_byte == 8'h5A, "R10 byte kept on bad frame", rx_byte, 8'h5A);
    wait_n(50);
    chk(rx_err, "R7 err held", rx_err, 1);
    do_ack();
    chk(!rx_err, "R7 ack clears err", rx_err, 0);

    // R6 stop error
    send(8'h81, 0, 0, 11);
    chk(rx_err && !rx_valid && rx_byte == 8'h5A, "R6 stop err", {rx_err, rx_valid, rx_byte}, 'h25A);
    do_ack();

    // R8 overrun
    send(8'h11, 0, 1, 11);
    send(8'h22, 0, 1, 11);
    chk(rx_valid && rx_overrun && rx_byte == 8'h22, "R8 overrun", {rx_overrun, rx_byte}, 'h122);
    wait_n(100);
    chk(rx_valid && rx_overrun, "R7 flags held", {rx_valid, rx_overrun}, 3);
    do_ack();
    chk(!rx_valid && !rx_overrun && !rx_err, "R7 ack clears all", {rx_valid, rx_overrun, rx_err}, 0);

    // R9 timeout
    send(8'hF0, 0, 1, 5);
    wait_n(TOUT + 100);
    chk(!rx_valid && !rx_err, "R9 no output from partial", {rx_valid, rx_err}, 0);
    send(8'h6B, 0, 1, 11);
    chk(rx_valid && rx_byte == 8'h6B && !rx_err, "R9 frame after timeout", rx_byte, 8'h6B);
    do_ack();

    summary();
  end
endmodule